// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the per-channel completion and error events of a multi-channel DMA engine and turns them into interrupt lines for a processor. It tracks five event kinds: whole-transfer done, block done, source-side transaction done, destination-side transaction done, and error. For each kind it keeps a latched event register, an enable mask, a derived status view and a write-one-to-clear register. Every one of these sits behind a simple register port. The write is synchronous and the read is combinational.

An event pulse from channel n sets bit n of that kind's latched register. The bit reaches the status view only when the mask bit is set and the channel's interrupt-enable input is high. The status views are OR-reduced into a five-bit combined register. They also drive one interrupt output per kind and one global interrupt, and all of these outputs share a polarity chosen at build time. Software handles an interrupt by reading the combined and status registers and then writing ones to the matching clear register. For self-test, software may also load the latched registers directly.

Top module: `dma_irq_agg`

## Requirements
- R1: Each event kind k (0 = transfer, 1 = block, 2 = source transaction, 3 = destination transaction, 4 = error) has a latched register at 0x2C0+8k, a read-only status register at 0x2E8+8k, a mask register at 0x310+8k and a clear register at 0x338+8k. Bit n of each register belongs to channel n.
- R2: Bits at and above the channel count read as 0 and ignore writes. A read of an unmapped or clear-register address returns 0.
- R3: After reset, every latched and mask bit is 0 and all interrupt outputs are at their inactive level.
- R4: An event pulse on channel n of kind k sets latched bit n of kind k on the next clock, whatever the mask and enable are.
- R5: A write to the clear register of kind k clears the latched bits where the write data is 1. Bits where the data is 0 are left unchanged.
- R6: A write to a latched register loads its channel bits directly from the write data.
- R7: If an event pulse coincides with a clear or a direct write to the same latched bit, the bit ends up set.
- R8: Status bit n of kind k equals latched bit AND mask bit AND channel n's interrupt-enable input. Writes to a status address change nothing.
- R9: The combined register at 0x360 holds, in bit k, the OR of all status bits of kind k. Its bits 5 and above read 0.
- R10: Output irq_type[k] is active exactly when combined bit k is 1, and irq_any is active when any combined bit is 1. When ACTIVE_LOW is 0 the active level is 1, and when it is 1 the active level is 0.
- R11: The mask registers are read/write at the channel positions and reset to 0, so every source is masked after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_tfr | input | NUM_CH | Per-channel transfer-done event pulses |
| evt_blk | input | NUM_CH | Per-channel block-done event pulses |
| evt_src | input | NUM_CH | Per-channel source-transaction-done pulses |
| evt_dst | input | NUM_CH | Per-channel destination-transaction-done pulses |
| evt_err | input | NUM_CH | Per-channel error pulses |
| ch_int_en | input | NUM_CH | Per-channel interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr (combinational) |
| irq_type | output | 5 | Per-kind interrupt, configured polarity |
| irq_any | output | 1 | Global interrupt, configured polarity |

## Verification
The hardest case to reach is an event pulse and a register write landing on the same latched bit in the same clock edge. The ports otherwise deliver these separately and in either order. The directed tests raise the event vector and the write strobe in the same half-cycle, both for a clear write and for a direct load. They also choose data in which some bits are hit only by the write, so both the winning and the non-colliding bits are visible in the readback. Gating is checked by dropping one channel's enable while its unmasked status bit is set. A second instance built with the opposite polarity, driven by identical stimulus, shows the inverted outputs.

// File: rtl/dma_irq_pkg.sv
// Package: shared constants and types for the DMA interrupt aggregator.
// Assumes a byte-addressed register space with an 8-byte register stride.
package dma_irq_pkg;
    localparam int NUM_TYPES = 5;
    localparam int STRIDE    = 8;
    localparam int RAW_BASE  = 'h2c0;
    localparam int STAT_BASE = 'h2e8;
    localparam int MASK_BASE = 'h310;
    localparam int CLR_BASE  = 'h338;
    localparam int COMB_ADDR = 'h360;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_RAW,
        RD_STAT,
        RD_MASK,
        RD_COMB
    } rd_kind_e;
endpackage

// File: rtl/dma_irq_decode.sv
// Module: address decoder. Turns the register address and write strobe into
// per-kind write enables and a read selector. Assumes exact address matches;
// writes to status, combined or unmapped addresses produce no enable.
module dma_irq_decode
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    output logic [NUM_TYPES-1:0] raw_we,
    output logic [NUM_TYPES-1:0] mask_we,
    output logic [NUM_TYPES-1:0] clr_we,
    output rd_kind_e             rd_kind,
    output logic [2:0]           rd_idx
);
    // Compare the address against each kind's register slots.
    always_comb begin
        raw_we  = '0;
        mask_we = '0;
        clr_we  = '0;
        rd_kind = RD_NONE;
        rd_idx  = '0;
        for (int k = 0; k < NUM_TYPES; k++) begin
            if (reg_addr == ADDR_W'(RAW_BASE + k*STRIDE)) begin
                raw_we[k] = reg_wr;
                rd_kind   = RD_RAW;
                rd_idx    = 3'(k);
            end
            if (reg_addr == ADDR_W'(STAT_BASE + k*STRIDE)) begin
                rd_kind = RD_STAT;
                rd_idx  = 3'(k);
            end
            if (reg_addr == ADDR_W'(MASK_BASE + k*STRIDE)) begin
                mask_we[k] = reg_wr;
                rd_kind    = RD_MASK;
                rd_idx     = 3'(k);
            end
            if (reg_addr == ADDR_W'(CLR_BASE + k*STRIDE)) begin
                clr_we[k] = reg_wr;
            end
        end
        if (reg_addr == ADDR_W'(COMB_ADDR)) begin
            rd_kind = RD_COMB;
        end
    end
endmodule

// File: rtl/dma_irq_family.sv
// Module: one event kind. Holds the latched event bits and the mask bits for
// all channels, and derives the status bits. Assumes at most one of raw_we and
// clr_we is high at a time, which the decoder guarantees. An event pulse always
// wins over a clear or a direct load.
module dma_irq_family #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic              raw_we,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] wdata,
    output logic [NUM_CH-1:0] raw_q,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] status
);
    logic [NUM_CH-1:0] raw_nxt;

    // Next latched value: load or clear first, then OR in new events.
    always_comb begin
        raw_nxt = raw_q;
        if (raw_we) begin
            raw_nxt = wdata;
        end else if (clr_we) begin
            raw_nxt = raw_q & ~wdata;
        end
        raw_nxt = raw_nxt | evt;
    end

    // Latched event register.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_nxt;
    end

    // Mask register, software written.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    assign status = raw_q & mask_q & ch_en;
endmodule

// File: rtl/dma_irq_out.sv
// Module: output stage. Reduces each kind's status bits to one combined bit
// and applies the build-time polarity to the interrupt outputs.
// Assumes status_flat holds kind k in slice [k*NUM_CH +: NUM_CH].
module dma_irq_out
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic [NUM_TYPES*NUM_CH-1:0] status_flat,
    output logic [NUM_TYPES-1:0]        combined,
    output logic [NUM_TYPES-1:0]        irq_type,
    output logic                        irq_any
);
    for (genvar k = 0; k < NUM_TYPES; k++) begin : g_red
        assign combined[k] = |status_flat[k*NUM_CH +: NUM_CH];
    end

    assign irq_type = combined ^ {NUM_TYPES{ACTIVE_LOW}};
    assign irq_any  = (|combined) ^ ACTIVE_LOW;
endmodule

// File: rtl/dma_irq_agg.sv
// Module: top of the DMA interrupt aggregator. Instantiates one event-kind
// slice per kind, the address decoder and the output stage, and builds the
// combinational read data. Assumes NUM_CH < DATA_W and NUM_CH >= 1.
module dma_irq_agg
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 64,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    evt_tfr,
    input  logic [NUM_CH-1:0]    evt_blk,
    input  logic [NUM_CH-1:0]    evt_src,
    input  logic [NUM_CH-1:0]    evt_dst,
    input  logic [NUM_CH-1:0]    evt_err,
    input  logic [NUM_CH-1:0]    ch_int_en,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [NUM_TYPES-1:0] irq_type,
    output logic                 irq_any
);
    localparam int FLAT_W = NUM_TYPES * NUM_CH;

    logic [FLAT_W-1:0]    evt_flat;
    logic [FLAT_W-1:0]    raw_flat;
    logic [FLAT_W-1:0]    mask_flat;
    logic [FLAT_W-1:0]    status_flat;
    logic [NUM_TYPES-1:0] raw_we;
    logic [NUM_TYPES-1:0] mask_we;
    logic [NUM_TYPES-1:0] clr_we;
    logic [NUM_TYPES-1:0] combined;
    rd_kind_e             rd_kind;
    logic [2:0]           rd_idx;
    logic                 unused_wdata_hi;

    assign evt_flat        = {evt_err, evt_dst, evt_src, evt_blk, evt_tfr};
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_CH];

    dma_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .raw_we   (raw_we),
        .mask_we  (mask_we),
        .clr_we   (clr_we),
        .rd_kind  (rd_kind),
        .rd_idx   (rd_idx)
    );

    for (genvar k = 0; k < NUM_TYPES; k++) begin : g_fam
        dma_irq_family #(.NUM_CH(NUM_CH)) u_fam (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_flat[k*NUM_CH +: NUM_CH]),
            .ch_en   (ch_int_en),
            .raw_we  (raw_we[k]),
            .mask_we (mask_we[k]),
            .clr_we  (clr_we[k]),
            .wdata   (reg_wdata[NUM_CH-1:0]),
            .raw_q   (raw_flat[k*NUM_CH +: NUM_CH]),
            .mask_q  (mask_flat[k*NUM_CH +: NUM_CH]),
            .status  (status_flat[k*NUM_CH +: NUM_CH])
        );
    end

    dma_irq_out #(.NUM_CH(NUM_CH), .ACTIVE_LOW(ACTIVE_LOW)) u_out (
        .status_flat (status_flat),
        .combined    (combined),
        .irq_type    (irq_type),
        .irq_any     (irq_any)
    );

    // Read multiplexer: select the addressed register, zero-extended.
    always_comb begin
        reg_rdata = '0;
        case (rd_kind)
            RD_RAW:  reg_rdata[NUM_CH-1:0]    = raw_flat[rd_idx*NUM_CH +: NUM_CH];
            RD_STAT: reg_rdata[NUM_CH-1:0]    = status_flat[rd_idx*NUM_CH +: NUM_CH];
            RD_MASK: reg_rdata[NUM_CH-1:0]    = mask_flat[rd_idx*NUM_CH +: NUM_CH];
            RD_COMB: reg_rdata[NUM_TYPES-1:0] = combined;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_irq_agg_chk.sv
// Module: assertion checker for dma_irq_agg, attached by bind below.
// Assumes the top's internal raw_flat and mask_flat carry kind k at
// slice [k*NUM_CH +: NUM_CH].
module dma_irq_agg_chk
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 64,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_wr,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [DATA_W-1:0]           reg_wdata,
    input logic [DATA_W-1:0]           reg_rdata,
    input logic [NUM_CH-1:0]           evt_tfr,
    input logic [NUM_CH-1:0]           evt_err,
    input logic [NUM_CH-1:0]           ch_int_en,
    input logic [NUM_TYPES-1:0]        irq_type,
    input logic                        irq_any,
    input logic [NUM_TYPES*NUM_CH-1:0] raw_flat,
    input logic [NUM_TYPES*NUM_CH-1:0] mask_flat
);
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NUM_CH] == '0); // R2

    AST_MASK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> mask_flat == '0); // R11

    AST_EVT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tfr != '0 |=> (raw_flat[NUM_CH-1:0] & $past(evt_tfr)) == $past(evt_tfr)); // R4

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err != '0 |=> (raw_flat[4*NUM_CH +: NUM_CH] & $past(evt_err)) == $past(evt_err)); // R7

    AST_CLEAR_TFR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(CLR_BASE) && evt_tfr == '0)
        |=> (raw_flat[NUM_CH-1:0] & $past(reg_wdata[NUM_CH-1:0])) == '0); // R5

    AST_NO_ENABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ch_int_en == '0 |-> irq_type == {NUM_TYPES{ACTIVE_LOW}}); // R8

    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(STAT_BASE)) |=> $stable(mask_flat)); // R8

    AST_ANY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_any != ACTIVE_LOW) == (irq_type != {NUM_TYPES{ACTIVE_LOW}})); // R10
endmodule

bind dma_irq_agg dma_irq_agg_chk #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACTIVE_LOW(ACTIVE_LOW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_tfr(evt_tfr),
    .evt_err(evt_err), .ch_int_en(ch_int_en), .irq_type(irq_type),
    .irq_any(irq_any), .raw_flat(raw_flat), .mask_flat(mask_flat)
);

// File: tb/tb_dma_irq_agg.sv
// Directed bench for dma_irq_agg: one task per scenario, each checks itself.
module tb_dma_irq_agg;
    localparam int NCH = 8;
    localparam logic [11:0] RAW  = 12'h2c0;
    localparam logic [11:0] STAT = 12'h2e8;
    localparam logic [11:0] MSK  = 12'h310;
    localparam logic [11:0] CLR  = 12'h338;
    localparam logic [11:0] COMB = 12'h360;

    logic clk = 1'b0;
    logic rst_n;
    logic [NCH-1:0] ev_tfr, ev_blk, ev_src, ev_dst, ev_err, en;
    logic reg_wr;
    logic [11:0] reg_addr;
    logic [63:0] reg_wdata, rdata, rdata_n;
    logic [4:0] irq_type, irq_type_n;
    logic irq_any, irq_any_n;
    int checks = 0;
    int fails  = 0;
    logic [63:0] d;

    always #10 clk = ~clk;

    dma_irq_agg #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .evt_tfr(ev_tfr), .evt_blk(ev_blk),
        .evt_src(ev_src), .evt_dst(ev_dst), .evt_err(ev_err), .ch_int_en(en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata), .irq_type(irq_type), .irq_any(irq_any)
    );

    dma_irq_agg #(.NUM_CH(NCH), .ACTIVE_LOW(1'b1)) dut_n (
        .clk(clk), .rst_n(rst_n), .evt_tfr(ev_tfr), .evt_blk(ev_blk),
        .evt_src(ev_src), .evt_dst(ev_dst), .evt_err(ev_err), .ch_int_en(en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_n), .irq_type(irq_type_n), .irq_any(irq_any_n)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] v);
        reg_addr = a;
        #1;
        v = rdata;
    endtask

    task automatic set_evt(input int k, input logic [NCH-1:0] b);
        case (k)
            0: ev_tfr = b;
            1: ev_blk = b;
            2: ev_src = b;
            3: ev_dst = b;
            default: ev_err = b;
        endcase
    endtask

    task automatic pulse(input int k, input logic [NCH-1:0] b);
        @(negedge clk);
        set_evt(k, b);
        @(negedge clk);
        set_evt(k, '0);
    endtask

    task automatic t_reset;
        rd(RAW, d);       chk("R3 raw tfr after reset", d, 0);
        rd(MSK + 32, d);  chk("R11 mask err after reset", d, 0);
        chk("R3 irq_type inactive", 64'(irq_type), 0);
        chk("R3 irq_any inactive", 64'(irq_any), 0);
        chk("R3 R10 active-low irq_any idle high", 64'(irq_any_n), 1);
    endtask

    task automatic t_event_raw;
        pulse(0, 8'h05);
        rd(RAW, d);  chk("R4 raw tfr set while masked", d, 64'h05);
        rd(STAT, d); chk("R11 masked status stays 0", d, 0);
        chk("R4 no interrupt while masked", 64'(irq_type), 0);
    endtask

    task automatic t_clear;
        wr(CLR, 64'h01);
        rd(RAW, d); chk("R5 clear bit0 only", d, 64'h04);
        wr(CLR, 64'h00);
        rd(RAW, d); chk("R5 zero clear no effect", d, 64'h04);
        rd(CLR, d); chk("R2 clear register reads 0", d, 0);
        wr(CLR, 64'hFF);
        rd(RAW, d); chk("R5 clear all", d, 0);
    endtask

    task automatic t_raw_write;
        wr(RAW + 32, 64'hFFFF_FFFF_FFFF_FF81);
        rd(RAW + 32, d); chk("R6 R2 direct load err, reserved ignored", d, 64'h81);
        wr(CLR + 32, 64'hFF);
        rd(RAW + 32, d); chk("R5 err cleared", d, 0);
    endtask

    task automatic t_mask_status;
        wr(MSK + 8, 64'h0000_0000_0000_FF0F);
        rd(MSK + 8, d); chk("R11 R2 mask readback", d, 64'h0F);
        pulse(1, 8'h30);
        rd(RAW + 8, d);  chk("R4 raw block", d, 64'h30);
        rd(STAT + 8, d); chk("R8 masked bits absent", d, 0);
        pulse(1, 8'h02);
        rd(STAT + 8, d); chk("R8 status block", d, 64'h02);
        rd(COMB, d);     chk("R9 combined block bit", d, 64'h02);
        chk("R10 irq_type high", 64'(irq_type), 64'h02);
        chk("R10 irq_any high", 64'(irq_any), 1);
        chk("R10 active-low irq_type", 64'(irq_type_n), 64'h1D);
        chk("R10 active-low irq_any", 64'(irq_any_n), 0);
    endtask

    task automatic t_enable_gate;
        @(negedge clk); en = 8'hFD;
        rd(STAT + 8, d); chk("R8 enable gates status", d, 0);
        chk("R8 enable gates output", 64'(irq_any), 0);
        @(negedge clk); en = 8'hFF;
        rd(STAT + 8, d); chk("R8 enable restored", d, 64'h02);
        wr(CLR + 8, 64'hFF);
        chk("R5 R10 output drops after clear", 64'(irq_any), 0);
    endtask

    task automatic t_collision;
        pulse(2, 8'h03);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = CLR + 16; reg_wdata = 64'h03; ev_src = 8'h01;
        @(negedge clk);
        reg_wr = 1'b0; ev_src = '0;
        rd(RAW + 16, d); chk("R7 event beats clear", d, 64'h01);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = RAW + 24; reg_wdata = 64'h01; ev_dst = 8'h80;
        @(negedge clk);
        reg_wr = 1'b0; ev_dst = '0;
        rd(RAW + 24, d); chk("R7 event beats direct load", d, 64'h81);
    endtask

    task automatic t_status_ro;
        wr(STAT, 64'hFF);
        rd(RAW, d); chk("R8 status write leaves raw", d, 0);
        rd(MSK, d); chk("R8 status write leaves mask", d, 0);
        rd(12'h000, d); chk("R2 unmapped reads 0", d, 0);
    endtask

    task automatic t_combined;
        wr(MSK + 32, 64'hFF);
        wr(RAW + 32, 64'h40);
        wr(MSK + 16, 64'h01);
        rd(COMB, d); chk("R9 R1 combined err and src", d, 64'h14);
        chk("R10 irq_type err and src", 64'(irq_type), 64'h14);
        rd(STAT + 32, d); chk("R1 R8 status err", d, 64'h40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        ev_tfr = '0; ev_blk = '0; ev_src = '0; ev_dst = '0; ev_err = '0;
        en = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_event_raw();
        t_clear();
        t_raw_write();
        t_mask_status();
        t_enable_gate();
        t_collision();
        t_status_ro();
        t_combined();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule